// File: doc/BRIEF.md
# Floating-Point Register File with Upper-Half Transfer Port

This block holds a bank of 64-bit floating-point registers and moves the upper 32-bit half of a double between the integer side and the FP side. It decodes two transfer instructions. One reads the upper half of an FP register and returns it sign-extended to 64 bits for an integer register. The other writes a 32-bit integer value into the upper half of an FP register.

A mode input picks how the registers are laid out. In wide mode each register holds a whole double. In narrow mode a double sits in an even/odd pair, with its upper half in the low 32 bits of the odd register. In narrow mode an odd register number in a transfer instruction is illegal. A read then returns a fixed poison word, and a write stores a different fixed poison word. A one-cycle warning flag marks the illegal access.

A second, plain 64-bit read port lets the FP side read any register directly. Writes happen on the rising clock edge. Reads are combinational from the current contents.

Top module: `fpr_hi_bridge`

## Requirements
- R1: An instruction is acted on only when `issue` is 1, bits 31:26 equal 010001, bits 10:0 are all zero and bits 25:21 equal 00011 (read-high) or 00111 (write-high). Any other input writes no register, leaves `rd_valid` at 0 and `rd_data` at 0, and raises no warning.
- R2: In wide mode (`fr64`=1), read-high sets `rd_valid` and returns bits 63:32 of register `instr[15:11]`, sign-extended. `int_reg` always shows `instr[20:16]`.
- R3: In wide mode, write-high replaces bits 63:32 of register `instr[15:11]` with `gpr_val`. Bits 31:0 of that register, and every other register, are kept.
- R4: In narrow mode (`fr64`=0) with an even register number N, read-high returns bits 31:0 of register N+1, sign-extended.
- R5: In narrow mode with an even N, write-high replaces bits 31:0 of register N+1 with `gpr_val`. Bits 63:32 of N+1, and all other registers, are kept.
- R6: In narrow mode with an odd N, read-high returns 64'h000000000BADF00D.
- R7: In narrow mode with an odd N, write-high stores 32'hDEADC0DE into bits 31:0 of register N and keeps its bits 63:32.
- R8: `warn` is 1 for the one cycle after each clock edge that sampled a decoded transfer with an odd register number in narrow mode. It is 0 at all other times, including odd numbers in wide mode.
- R9: A synchronous active-high `rst` clears every register to zero and clears `warn`.
- R10: Whenever `rd_valid` is 1, `rd_data[63:32]` equals copies of `rd_data[31]`.
- R11: `peek_data` shows the full 64-bit contents of register `peek_idx` combinationally. A write shows there only after the clock edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fr64 | input | 1 | 1 = wide 64-bit registers, 0 = narrow paired layout |
| issue | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| gpr_val | input | 32 | Low 32 bits of the integer source register for write-high |
| rd_data | output | 64 | Sign-extended read-high result, zero when not reading |
| rd_valid | output | 1 | A read-high is decoded this cycle |
| int_reg | output | 5 | Integer register number from the instruction |
| warn | output | 1 | Registered pulse for an illegal odd register in narrow mode |
| peek_idx | input | 5 | Register number for the direct read port |
| peek_data | output | 64 | Full contents of register `peek_idx` |

## Verification
Some properties are checked on every cycle. A read never writes. No write touches both halves of a register at once. The warning only follows a narrow-mode cycle. Read results are always sign-extended. Reset leaves a zero bank, and the direct read port stays stable while nothing is written.

Other behaviour only shows up in the bench's sweeps over every register number in both modes. These sweeps cover the redirection to the odd partner, the two poison words, which half a write lands in, and whether malformed encodings are truly ignored. After each write the bench reads back the whole bank, so a write to the wrong register or the wrong half is caught.

// File: rtl/fpr_hi_pkg.sv
package fpr_hi_pkg;

  localparam logic [5:0]  MAJOR_FP   = 6'b010001;
  localparam logic [4:0]  SUB_RDHI   = 5'b00011;
  localparam logic [4:0]  SUB_WRHI   = 5'b00111;
  localparam logic [31:0] POISON_RD  = 32'h0BADF00D;
  localparam logic [31:0] POISON_WR  = 32'hDEADC0DE;

  typedef struct packed {
    logic       rdhi;
    logic       wrhi;
    logic [4:0] ireg;
    logic [4:0] freg;
  } hx_op_t;

endpackage

// File: rtl/fpr_hi_decode.sv
module fpr_hi_decode
  import fpr_hi_pkg::*;
(
  input  logic        issue,
  input  logic [31:0] instr,
  output hx_op_t      op
);

  logic shape_ok;

  always_comb begin
    shape_ok = issue && (instr[31:26] == MAJOR_FP) && (instr[10:0] == 11'd0);
    op.rdhi  = shape_ok && (instr[25:21] == SUB_RDHI);
    op.wrhi  = shape_ok && (instr[25:21] == SUB_WRHI);
    op.ireg  = instr[20:16];
    op.freg  = instr[15:11];
  end

endmodule

// File: rtl/fpr_hi_regbank.sv
module fpr_hi_regbank #(
  parameter int NREGS = 32,
  parameter int HALF  = 32,
  localparam int AW   = $clog2(NREGS),
  localparam int W    = 2 * HALF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_lo,
  input  logic            we_hi,
  input  logic [AW-1:0]   waddr,
  input  logic [HALF-1:0] wdata_lo,
  input  logic [HALF-1:0] wdata_hi,
  input  logic [AW-1:0]   raddr_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [W-1:0]    rdata_a,
  output logic [W-1:0]    rdata_b
);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [HALF-1:0] mem [NREGS];
    logic            we;
    logic [HALF-1:0] wd;

    assign we = (g == 0) ? we_lo : we_hi;
    assign wd = (g == 0) ? wdata_lo : wdata_hi;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < NREGS; k++) mem[k] <= '0;
      end else if (we) begin
        mem[waddr] <= wd;
      end
    end

    assign rdata_a[g*HALF +: HALF] = mem[raddr_a];
    assign rdata_b[g*HALF +: HALF] = mem[raddr_b];
  end

  // R3 R5
  one_half_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({we_lo, we_hi}));

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rdata_b == '0));

  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(we_lo || we_hi) |=> (!$stable(raddr_b) || $stable(rdata_b)));

endmodule

// File: rtl/fpr_hi_bridge.sv
module fpr_hi_bridge
  import fpr_hi_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN  = 64,
  localparam int HALF = XLEN / 2,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fr64,
  input  logic            issue,
  input  logic [31:0]     instr,
  input  logic [HALF-1:0] gpr_val,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_valid,
  output logic [4:0]      int_reg,
  output logic            warn,
  input  logic [AW-1:0]   peek_idx,
  output logic [XLEN-1:0] peek_data
);

  hx_op_t          op;
  logic [AW-1:0]   fidx;
  logic [AW-1:0]   tidx;
  logic            odd_n;
  logic            bad;
  logic [HALF-1:0] rd_half;
  logic            we_lo, we_hi;
  logic [HALF-1:0] wd_lo;
  logic [XLEN-1:0] bank_rd;
  logic            warn_q;

  fpr_hi_decode u_dec (
    .issue (issue),
    .instr (instr),
    .op    (op)
  );

  always_comb begin
    fidx    = op.freg[AW-1:0];
    odd_n   = fidx[0];
    bad     = !fr64 && odd_n && (op.rdhi || op.wrhi);
    tidx    = (!fr64 && !odd_n) ? (fidx | AW'(1)) : fidx;
    if (fr64)       rd_half = bank_rd[XLEN-1:HALF];
    else if (odd_n) rd_half = POISON_RD;
    else            rd_half = bank_rd[HALF-1:0];
    rd_valid = op.rdhi;
    rd_data  = op.rdhi ? {{HALF{rd_half[HALF-1]}}, rd_half} : '0;
    int_reg  = op.ireg;
    we_hi    = op.wrhi && fr64;
    we_lo    = op.wrhi && !fr64;
    wd_lo    = odd_n ? POISON_WR : gpr_val;
  end

  fpr_hi_regbank #(.NREGS(NREGS), .HALF(HALF)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we_lo    (we_lo),
    .we_hi    (we_hi),
    .waddr    (tidx),
    .wdata_lo (wd_lo),
    .wdata_hi (gpr_val),
    .raddr_a  (tidx),
    .raddr_b  (peek_idx),
    .rdata_a  (bank_rd),
    .rdata_b  (peek_data)
  );

  always_ff @(posedge clk) begin
    if (rst) warn_q <= 1'b0;
    else     warn_q <= bad;
  end
  assign warn = warn_q;

  // R10
  sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[XLEN-1:HALF] == {HALF{rd_data[HALF-1]}}));

  // R2
  read_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !(we_lo || we_hi));

  // R8
  warn_narrow_chk: assert property (@(posedge clk) disable iff (rst)
    warn |-> $past(!fr64 && issue));

endmodule

// File: tb/test_fpr_hi_bridge.sv
module test_fpr_hi_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 32;
  localparam int XLEN  = 64;
  localparam int HALF  = 32;

  logic clk = 1'b0, rst = 1'b1, fr64 = 1'b1, issue = 1'b0;
  logic [31:0] instr = '0;
  logic [HALF-1:0] gpr_val = '0;
  logic [XLEN-1:0] rd_data, peek_data;
  logic rd_valid, warn;
  logic [4:0] int_reg;
  logic [4:0] peek_idx = '0;

  int nvec = 0, nbad = 0;
  logic [31:0] m_lo [NREGS];
  logic [31:0] m_hi [NREGS];

  fpr_hi_bridge i_fpr_hi_bridge (
    .clk(clk), .rst(rst), .fr64(fr64), .issue(issue), .instr(instr),
    .gpr_val(gpr_val), .rd_data(rd_data), .rd_valid(rd_valid),
    .int_reg(int_reg), .warn(warn), .peek_idx(peek_idx), .peek_data(peek_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [5:0] maj, logic [4:0] sub,
                                      logic [4:0] rt, logic [4:0] fs, logic [10:0] low);
    return {maj, sub, rt, fs, low};
  endfunction

  function automatic logic [63:0] sx(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic sweep(string req);
    for (int i = 0; i < NREGS; i++) begin
      peek_idx = 5'(i);
      #1;
      chk(req, peek_data, {m_hi[i], m_lo[i]});
    end
  endtask

  task automatic run_op(logic mode, logic go, logic [31:0] ins, logic [31:0] val,
                        logic exp_valid, logic [63:0] exp_rd, logic exp_warn, string req);
    @(negedge clk);
    fr64 = mode; issue = go; instr = ins; gpr_val = val;
    #1;
    chk({req, " R1 valid"}, {63'd0, rd_valid}, {63'd0, exp_valid});
    chk({req, " R10 data"}, rd_data, exp_rd);
    chk("R2 int_reg", {59'd0, int_reg}, {59'd0, ins[20:16]});
    @(negedge clk);
    issue = 1'b0; instr = '0;
    #1;
    chk({req, " R8 warn"}, {63'd0, warn}, {63'd0, exp_warn});
    @(negedge clk);
    #1;
    chk("R8 one cycle", {63'd0, warn}, 64'd0);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NREGS; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R9 warn", {63'd0, warn}, 64'd0);
    sweep("R9");

    // wide write-high on every register
    for (int i = 0; i < NREGS; i++) begin
      v = 32'h9E3779B9 * (i + 1) ^ (i << 3);
      peek_idx = 5'(i); #1;
      chk("R11 before", peek_data, {m_hi[i], m_lo[i]});
      run_op(1'b1, 1'b1, enc(6'b010001, 5'b00111, 5'(i*7), 5'(i), 11'd0), v, 1'b0, 64'd0, 1'b0, "R3");
      m_hi[i] = v;
      peek_idx = 5'(i); #1;
      chk("R11 after", peek_data, {m_hi[i], m_lo[i]});
    end
    sweep("R3");

    // wide read-high
    for (int i = 0; i < NREGS; i++)
      run_op(1'b1, 1'b1, enc(6'b010001, 5'b00011, 5'(31-i), 5'(i), 11'd0), 32'h0,
             1'b1, sx(m_hi[i]), 1'b0, "R2");

    // narrow write-high: odd first, then even
    for (int i = 1; i < NREGS; i += 2) begin
      run_op(1'b0, 1'b1, enc(6'b010001, 5'b00111, 5'(i), 5'(i), 11'd0), 32'h12345678,
             1'b0, 64'd0, 1'b1, "R7");
      m_lo[i] = 32'hDEADC0DE;
      sweep("R7");
    end
    for (int i = 0; i < NREGS; i += 2) begin
      v = 32'h7F4A7C15 * (i + 3) + 32'h80000000 * (i % 4 == 0 ? 1 : 0);
      run_op(1'b0, 1'b1, enc(6'b010001, 5'b00111, 5'(i), 5'(i), 11'd0), v,
             1'b0, 64'd0, 1'b0, "R5");
      m_lo[i+1] = v;
      sweep("R5");
    end

    // narrow read-high
    for (int i = 0; i < NREGS; i++) begin
      if (i % 2 == 1)
        run_op(1'b0, 1'b1, enc(6'b010001, 5'b00011, 5'(i), 5'(i), 11'd0), 32'h0,
               1'b1, 64'h000000000BADF00D, 1'b1, "R6");
      else
        run_op(1'b0, 1'b1, enc(6'b010001, 5'b00011, 5'(i), 5'(i), 11'd0), 32'h0,
               1'b1, sx(m_lo[i+1]), 1'b0, "R4");
    end

    // malformed or unissued words, both modes, odd and even numbers
    for (int m = 0; m < 2; m++) begin
      for (int f = 4; f < 6; f++) begin
        run_op(m[0], 1'b1, enc(6'b010010, 5'b00111, 5'd1, 5'(f), 11'd0), 32'hFFFFFFFF, 1'b0, 64'd0, 1'b0, "R1 major");
        run_op(m[0], 1'b1, enc(6'b010001, 5'b00110, 5'd1, 5'(f), 11'd0), 32'hFFFFFFFF, 1'b0, 64'd0, 1'b0, "R1 sub");
        run_op(m[0], 1'b1, enc(6'b010001, 5'b00111, 5'd1, 5'(f), 11'h400), 32'hFFFFFFFF, 1'b0, 64'd0, 1'b0, "R1 low");
        run_op(m[0], 1'b1, enc(6'b010001, 5'b00011, 5'd1, 5'(f), 11'd1), 32'hFFFFFFFF, 1'b0, 64'd0, 1'b0, "R1 low rd");
        run_op(m[0], 1'b0, enc(6'b010001, 5'b00111, 5'd1, 5'(f), 11'd0), 32'hFFFFFFFF, 1'b0, 64'd0, 1'b0, "R1 issue");
      end
    end
    sweep("R1");

    // reset again with a populated bank
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NREGS; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    #1;
    chk("R9 warn", {63'd0, warn}, 64'd0);
    sweep("R9");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule